// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one column command into the run of column addresses that an SDRAM burst touches. A controller first writes its mode word into a local copy held by the block. The low fields of that word select the burst length (1, 2, 4, 8 or a whole page) and the visiting order (linear or interleaved). The CAS latency field is exposed, unchanged, to the data-path timing logic.

When a read or write command is issued, the controller pulses `start` with the first column. From the next cycle onward the block presents one column per clock, with a valid flag and a flag on the final beat. A burst ends when its length runs out, when `stop` is pulsed, or when a new `start` replaces it. A whole-page burst has no natural end and circles the page until it is stopped or replaced. The page width is the column width parameter: 9, 10 or 11 bits match the 16-, 8- and 4-bit-wide device organizations.

Top module: `sdr_burst_colgen`

## Requirements
- R1: While reset is held and after it is released, `col_valid` and `col_last` are 0, `col_out` is 0 and `cas_lat` is 0.
- R2: A `mode_wr` pulse stores `mode_word`. From the next cycle, `cas_lat` equals bits 6..4 of the stored word.
- R3: Bits 2..0 of the stored word select the length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. `col_last` is high on the final beat only, and `col_valid` falls in the following cycle.
- R4: Length codes 100, 101 and 110 behave as a length of 1.
- R5: With bit 3 at 0 (linear order), the low log2(length) bits of the column count up from the start column and wrap inside the aligned block. The bits above them keep the start column's value.
- R6: With bit 3 at 1 (interleaved order) and a length of 2, 4 or 8, the low log2(length) bits on beat k equal the start column's low bits XOR k. The upper bits are unchanged.
- R7: Length code 111 runs a linear burst over the whole page of 2^COL_W columns. It wraps from the top column to 0, never raises `col_last`, and ignores bit 3.
- R8: The cycle after a `start` pulse, `col_valid` is 1 and `col_out` equals `start_col`. A `start` during a burst abandons that burst.
- R9: A `stop` pulse with no `start` makes `col_valid` 0 in the next cycle, and this includes whole-page bursts. When `start` and `stop` arrive together, `start` wins.
- R10: The length and order of a burst are fixed by the stored word at the moment of its `start`. A `mode_wr` during the burst, or in the same cycle as `start`, affects only later bursts.
- R11: `col_out` is 0 whenever `col_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Store `mode_word` into the local mode copy |
| mode_word | input | MODE_W | Mode word: length in 2..0, order in 3, latency in 6..4 |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | COL_W | First column of the burst |
| stop | input | 1 | End the current burst |
| col_out | output | COL_W | Column of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | Current beat is the final one of a fixed-length burst |
| cas_lat | output | 3 | Latency field of the stored mode word |

## Verification
Every result is due exactly one rising edge after its cause. The first column follows `start` by one edge, `cas_lat` follows `mode_wr` by one edge, and `col_valid` falls one edge after `stop` or after the beat that carries `col_last`. The bench drives all inputs on the falling edge and advances its own model on the rising edge that consumes them. It compares every output on the next falling edge, so each comparison lands in the cycle where that result is due. Directed runs cover each length code, both orders, page wrap, simultaneous `start` and `stop`, and mode writes during a burst. Seeded random traffic then mixes these events freely.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

   // Field positions inside the stored mode word (decoded by this block).
   localparam int LEN_LSB  = 0;
   localparam int ORD_BIT  = 3;
   localparam int LAT_LSB  = 4;
   localparam int MIN_MODE_W = 7;

   typedef struct packed {
      logic       page;   // whole-page linear burst
      logic       intl;   // interleaved order in force
      logic [2:0] lenm1;  // beats minus one for fixed lengths
   } burst_cfg_t;

   function automatic burst_cfg_t decode_cfg(input logic [2:0] code, input logic ord);
      burst_cfg_t c;
      c.page  = 1'b0;
      c.lenm1 = 3'd0;
      unique case (code)
         3'b001:  c.lenm1 = 3'd1;
         3'b010:  c.lenm1 = 3'd3;
         3'b011:  c.lenm1 = 3'd7;
         3'b111: begin
            c.page  = 1'b1;
            c.lenm1 = 3'd7;
         end
         default: c.lenm1 = 3'd0;
      endcase
      c.intl = ord & ~c.page;
      return c;
   endfunction

endpackage

// File: rtl/sdr_mode_store.sv
module sdr_mode_store
   import sdr_burst_pkg::*;
#(
   parameter int MODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_word,
   output burst_cfg_t        cfg,
   output logic [2:0]        cas_lat
);

   generate
      if (MODE_W < MIN_MODE_W) begin : g_bad_mode_w
         $error("sdr_mode_store: MODE_W must be at least 7");
      end
   endgenerate

   logic [MODE_W-1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_wr) mode_q <= mode_word;
   end

   assign cfg     = decode_cfg(mode_q[LEN_LSB +: 3], mode_q[ORD_BIT]);
   assign cas_lat = mode_q[LAT_LSB +: 3];

   AST_LAT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> cas_lat == $past(mode_word[LAT_LSB +: 3])); // R2

endmodule

// File: rtl/sdr_beat_ctrl.sv
module sdr_beat_ctrl
   import sdr_burst_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic             stop,
   input  burst_cfg_t       cfg,
   output logic             active,
   output logic [COL_W-1:0] beat,
   output logic [COL_W-1:0] base,
   output burst_cfg_t       cfg_q,
   output logic             last
);

   localparam int PAD_W = COL_W - 3;

   assign last = active & ~cfg_q.page & (beat == {{PAD_W{1'b0}}, cfg_q.lenm1});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         beat   <= '0;
         base   <= '0;
         cfg_q  <= '0;
      end else if (start) begin
         active <= 1'b1;
         beat   <= '0;
         base   <= start_col;
         cfg_q  <= cfg;
      end else if (stop) begin
         active <= 1'b0;
      end else if (active) begin
         if (last) active <= 1'b0;
         else      beat   <= beat + 1'b1;
      end
   end

   AST_BEAT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      active && !start && !stop && !last |=> active && beat == $past(beat) + 1'b1); // R5

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      active && !start |=> cfg_q == $past(cfg_q)); // R10

endmodule

// File: rtl/sdr_col_order.sv
module sdr_col_order
   import sdr_burst_pkg::*;
#(
   parameter int COL_W       = 9,
   parameter bit SUPPORT_INTL = 1'b1
) (
   input  logic             active,
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   input  burst_cfg_t       cfg_q,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] msk;
   logic [COL_W-1:0] lin;
   logic [COL_W-1:0] xor_col;
   logic [COL_W-1:0] sum;
   logic             use_x;

   assign sum = base + beat;

   generate
      for (genvar i = 0; i < COL_W; i++) begin : g_bit
         if (i < 3) begin : g_low
            assign msk[i] = cfg_q.page | cfg_q.lenm1[i];
         end else begin : g_high
            assign msk[i] = cfg_q.page;
         end
         assign lin[i]     = msk[i] ? sum[i]            : base[i];
         assign xor_col[i] = msk[i] ? base[i] ^ beat[i] : base[i];
      end

      if (SUPPORT_INTL) begin : g_intl
         assign use_x = cfg_q.intl;
      end else begin : g_lin_only
         assign use_x = 1'b0;
      end
   endgenerate

   assign col = active ? (use_x ? xor_col : lin) : '0;

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
   import sdr_burst_pkg::*;
#(
   parameter int COL_W        = 9,
   parameter int MODE_W       = 12,
   parameter bit SUPPORT_INTL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_word,
   input  logic              start,
   input  logic [COL_W-1:0]  start_col,
   input  logic              stop,
   output logic [COL_W-1:0]  col_out,
   output logic              col_valid,
   output logic              col_last,
   output logic [2:0]        cas_lat
);

   generate
      if (COL_W < 3 || COL_W > 16) begin : g_bad_col_w
         $error("sdr_burst_colgen: COL_W must lie in 3..16");
      end
   endgenerate

   burst_cfg_t       cfg;
   burst_cfg_t       cfg_q;
   logic             active;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] base;
   logic             last;

   sdr_mode_store #(.MODE_W(MODE_W)) i_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (mode_wr),
      .mode_word (mode_word),
      .cfg       (cfg),
      .cas_lat   (cas_lat)
   );

   sdr_beat_ctrl #(.COL_W(COL_W)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_col (start_col),
      .stop      (stop),
      .cfg       (cfg),
      .active    (active),
      .beat      (beat),
      .base      (base),
      .cfg_q     (cfg_q),
      .last      (last)
   );

   sdr_col_order #(.COL_W(COL_W), .SUPPORT_INTL(SUPPORT_INTL)) i_order (
      .active (active),
      .base   (base),
      .beat   (beat),
      .cfg_q  (cfg_q),
      .col    (col_out)
   );

   assign col_valid = active;
   assign col_last  = last;

   AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      col_last |-> col_valid); // R3

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      col_last && !start |=> !col_valid); // R3

   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> col_valid && col_out == $past(start_col)); // R8

   AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      stop && !start |=> !col_valid); // R9

   AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      col_valid && $past(col_valid) && !$past(start) && !cfg_q.page
      |-> col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])); // R5

endmodule

// File: tb/test_sdr_burst_colgen.sv
module test_sdr_burst_colgen;

   localparam int COL_W  = 9;
   localparam int MODE_W = 12;
   localparam int PAGE   = 1 << COL_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode_wr = 1'b0;
   logic [MODE_W-1:0] mode_word = '0;
   logic              start = 1'b0;
   logic [COL_W-1:0]  start_col = '0;
   logic              stop = 1'b0;
   logic [COL_W-1:0]  col_out;
   logic              col_valid;
   logic              col_last;
   logic [2:0]        cas_lat;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model state
   int m_mode   = 0;
   bit m_active = 1'b0;
   int m_beat   = 0;
   int m_base   = 0;
   int m_len    = 1;   // 0 means whole page
   bit m_intl   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sdr_burst_colgen #(.COL_W(COL_W), .MODE_W(MODE_W)) i_sdr_burst_colgen (
      .clk, .rst_n, .mode_wr, .mode_word, .start, .start_col, .stop,
      .col_out, .col_valid, .col_last, .cas_lat
   );

   function automatic int len_of(input int code);
      case (code)
         1: return 2;
         2: return 4;
         3: return 8;
         7: return 0;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col();
      int mask;
      int lowpart;
      if (!m_active) return 0;
      mask = (m_len == 0) ? PAGE - 1 : m_len - 1;
      if (m_intl && m_len != 0) lowpart = (m_base ^ m_beat) & mask;
      else                      lowpart = (m_base + m_beat) & mask;
      return (m_base & ~mask & (PAGE - 1)) | lowpart;
   endfunction

   task automatic check(input string tag);
      int  ec;
      bit  el;
      ec = exp_col();
      el = m_active && m_len != 0 && m_beat == m_len - 1;
      checks++;
      if (col_out !== COL_W'(ec) || col_valid !== m_active || col_last !== el
          || cas_lat !== 3'((m_mode >> 4) & 7)) begin
         fails++;
         $display("FAIL %s: got col=%0d valid=%0b last=%0b lat=%0d, expected col=%0d valid=%0b last=%0b lat=%0d",
                  tag, col_out, col_valid, col_last, cas_lat, ec, m_active, el, (m_mode >> 4) & 7);
      end
   endtask

   // drive at the falling edge, model at the rising edge, check at the next falling edge
   task automatic tick(input bit s, input int sc, input bit sp, input bit mw, input int mword,
                       input string tag);
      start     = s;
      start_col = COL_W'(sc);
      stop      = sp;
      mode_wr   = mw;
      mode_word = MODE_W'(mword);
      @(posedge clk);
      if (s) begin
         m_active = 1'b1;
         m_beat   = 0;
         m_base   = sc & (PAGE - 1);
         m_len    = len_of(m_mode & 7);
         m_intl   = ((m_mode >> 3) & 1) != 0;
      end else if (sp) begin
         m_active = 1'b0;
      end else if (m_active) begin
         if (m_len != 0 && m_beat == m_len - 1) m_active = 1'b0;
         else m_beat = (m_beat + 1) & (PAGE - 1);
      end
      if (mw) m_mode = mword & ((1 << MODE_W) - 1);
      @(negedge clk);
      check(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, tag);
   endtask

   task automatic burst(input int mword, input int sc, input int n, input string tag);
      tick(0, 0, 0, 1, mword, tag);
      tick(1, sc, 0, 0, 0, tag);
      idle(n, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks + 1);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");
      idle(2, "R11");

      tick(0, 0, 0, 1, 12'h030, "R2");
      tick(0, 0, 0, 1, 12'h5A0, "R2");

      // fixed lengths, linear order
      burst(12'h020, 9'h13D, 3, "R3");
      burst(12'h021, 9'h13D, 3, "R3");
      burst(12'h022, 9'h13E, 5, "R5");
      burst(12'h023, 9'h0FB, 10, "R5");
      // unused length codes
      burst(12'h024, 9'h077, 3, "R4");
      burst(12'h025, 9'h078, 3, "R4");
      burst(12'h026, 9'h079, 3, "R4");
      // interleaved
      burst(12'h029, 9'h133, 3, "R6");
      burst(12'h02A, 9'h1A6, 5, "R6");
      burst(12'h02B, 9'h0C5, 10, "R6");
      // whole page, with order bit set (ignored), wraps then stopped
      burst(12'h02F, 9'h1F0, PAGE + 20, "R7");
      tick(0, 0, 1, 0, 0, "R9");
      idle(2, "R11");
      // interrupt a burst with a new start
      burst(12'h023, 9'h010, 3, "R8");
      tick(1, 9'h1FE, 0, 0, 0, "R8");
      idle(9, "R8");
      // start and stop together
      tick(1, 9'h040, 0, 0, 0, "R9");
      tick(1, 9'h0A0, 1, 0, 0, "R9");
      tick(0, 0, 1, 0, 0, "R9");
      // mode write while a burst runs and at the same edge as start
      tick(0, 0, 0, 1, 12'h032, "R10");
      tick(1, 9'h101, 0, 0, 0, "R10");
      tick(0, 0, 0, 1, 12'h020, "R10");
      idle(4, "R10");
      tick(1, 9'h105, 0, 1, 12'h023, "R10");
      idle(2, "R10");
      tick(1, 9'h105, 0, 0, 0, "R10");
      idle(9, "R10");

      // seeded random mix
      for (int i = 0; i < 4000; i++) begin
         int  r;
         bit  s, sp, mw;
         r  = $urandom;
         s  = (r % 8) == 0;
         sp = ((r >> 4) % 16) == 0;
         mw = ((r >> 9) % 20) == 0;
         tick(s, $urandom % PAGE, sp, mw, $urandom % (1 << MODE_W), "R8");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule